// File: doc/BRIEF.md
# Register-File String Load/Store Sequencer

This block runs a multi-cycle transfer between a 32-entry register file and a byte-addressed memory port. A command gives an operation type, a first register, a first address, a byte count and an endian flag. The block then issues memory accesses one at a time, and for loads it writes the results into the register file. For stores it reads registers and writes their contents to memory.

There are two families of operation. A multiple-word transfer handles one 32-bit word per register, from the first register through register 31. A string transfer moves the number of bytes given by the byte count. It moves whole words while at least four bytes remain, wrapping the register index from 31 back to 0, and then moves any remaining one to three bytes with single-byte accesses. In little-endian mode every whole word is byte-reversed, and the trailing bytes are packed from the low byte lane upward rather than from the high lane downward.

Top module: `regstr_seq`

## Requirements
- R1: Operation code 2'b00 (word load) and 2'b01 (word store) each move one word per register, from the first register through register 31. Each word uses a word access (`mem_req_byte`=0), and the address grows by 4 after each word. The byte count is ignored.
- R2: Operation code 2'b10 (string load) and 2'b11 (string store) issue word accesses while the remaining count is above 3. After each word the count drops by 4, the address rises by 4 and the register index rises by one, wrapping from 31 to 0.
- R3: A remainder of 1 to 3 bytes is moved with one byte access per byte (`mem_req_byte`=1), and the address rises by 1 per byte. A byte access carries its data in bits [7:0] of the data buses.
- R4: With `cmd_le`=0, a string load places trailing byte k (k=0,1,2) at register bits 31-8k down to 24-8k, and clears every lane that received no byte.
- R5: With `cmd_le`=1, a string load places trailing byte k at register bits 8k+7 down to 8k, and clears every lane that received no byte.
- R6: A word access puts the byte at the lowest address in data bits [31:24]. With `cmd_le`=0 the register word equals the memory word. With `cmd_le`=1 it is byte-reversed, for both loads and stores.
- R7: A string store of a remainder writes only the remaining bytes. They come from the current register, in the same lane order the load uses for that endian mode. A store never writes the register file.
- R8: A string operation with a byte count of zero raises `done` in the cycle after acceptance, with no memory access and no register write.
- R9: No more than one memory access is outstanding. A request is held, with address and size unchanged, until `mem_req_ready` accepts it.
- R10: `done` is high for exactly one cycle, in the cycle after the last response. `cmd_ready` is high only while idle, and a command presented while busy is ignored. After reset the block is idle, with `done`, `mem_req_valid` and `rf_wr_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Idle, so a command will be taken |
| cmd_op | input | 2 | 00 word load, 01 word store, 10 string load, 11 string store |
| cmd_reg | input | 5 | First register |
| cmd_addr | input | AW | First byte address |
| cmd_count | input | CW | Byte count (string operations only) |
| cmd_le | input | 1 | Little-endian mode |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_byte | output | 1 | 1 = byte access, 0 = word access |
| mem_req_addr | output | AW | Access address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response for the outstanding access |
| mem_rsp_rdata | input | 32 | Read data |
| rf_rd_idx | output | 5 | Register read index |
| rf_rd_data | input | 32 | Register read data (combinational) |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_idx | output | 5 | Register write index |
| rf_wr_data | output | 32 | Register write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a string transfer in which, in a single command, the register index wraps from 31 to 0 and a partial trailing word is then packed into the wrapped register. The stimulus table starts string loads and stores at registers 30 and 31, with counts that leave one, two or three trailing bytes, in both endian modes. The memory model also drops its ready at pseudo-random times, so every request spends a varying number of cycles waiting while it must stay stable. A dedicated case presents a second command while a transfer is running and then checks that the second command's target memory is untouched.

// File: rtl/regstr_pkg.sv
// Shared constants and encodings for the register-file string sequencer.
// Assumes 32-bit registers made of four byte lanes and a 32-entry file.
package regstr_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int NUM_REGS   = 32;
    localparam int RIDX_W     = $clog2(NUM_REGS);

    typedef enum logic [1:0] {
        OP_MW_LOAD   = 2'b00,
        OP_MW_STORE  = 2'b01,
        OP_STR_LOAD  = 2'b10,
        OP_STR_STORE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FINISH
    } st_e;
endpackage

// File: rtl/regstr_swap.sv
// Optional byte reversal of a word. When en is high, byte lane b of the
// output takes lane BYTES-1-b of the input; otherwise data passes unchanged.
// Purely combinational; assumes the width is a whole number of bytes.
module regstr_swap #(
    parameter int BYTES = 4
) (
    input  logic               en,
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);
    logic [8*BYTES-1:0] rev;

    // Mirror the byte lanes.
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign rev[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
    end

    assign dout = en ? rev : din;
endmodule

// File: rtl/regstr_lane.sv
// Trailing-byte lane steering. Trailing byte idx lives in lane idx
// (little-endian) or in lane BYTES-1-idx (big-endian). Merges a loaded byte
// into the accumulator and picks the byte to store from a register.
// Combinational; assumes BYTES is a power of two.
module regstr_lane #(
    parameter int BYTES = 4,
    localparam int IW   = $clog2(BYTES),
    localparam int SW   = IW + 3
) (
    input  logic               le,
    input  logic [IW-1:0]      idx,
    input  logic [8*BYTES-1:0] acc_in,
    input  logic [7:0]         byte_in,
    input  logic [8*BYTES-1:0] reg_in,
    output logic [8*BYTES-1:0] acc_out,
    output logic [7:0]         byte_out
);
    logic [IW-1:0] lane;
    logic [SW-1:0] sh;

    // Pick the lane and turn it into a bit offset.
    always_comb begin
        lane = le ? idx : (IW'(BYTES - 1) - idx);
        sh   = {lane, 3'b000};
    end

    assign acc_out  = acc_in | ({{(8*BYTES-8){1'b0}}, byte_in} << sh);
    assign byte_out = 8'(reg_in >> sh);
endmodule

// File: rtl/regstr_seq.sv
// Register-file string load/store sequencer (top).
// Accepts one command while idle, then issues memory accesses one at a time
// (valid/ready request, single-beat response) and steps through registers.
// Assumes the register file read is combinational and a write takes effect
// at the clock edge where rf_wr_en is high.
module regstr_seq
    import regstr_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [RIDX_W-1:0] cmd_reg,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [CW-1:0]     cmd_count,
    input  logic              cmd_le,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic              mem_req_byte,
    output logic [AW-1:0]     mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_rdata,
    output logic [RIDX_W-1:0] rf_rd_idx,
    input  logic [WORD_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [RIDX_W-1:0] rf_wr_idx,
    output logic [WORD_W-1:0] rf_wr_data,
    output logic              done
);
    localparam int IW = $clog2(WORD_BYTES);

    st_e               st_q;
    op_e               op_q;
    logic              le_q;
    logic [RIDX_W-1:0] reg_q;
    logic [AW-1:0]     addr_q;
    logic [CW-1:0]     rem_q;
    logic [IW-1:0]     tail_q;
    logic [WORD_W-1:0] acc_q;

    logic              is_str, is_store, word_step, last_tail, rsp_take;
    logic [WORD_W-1:0] load_word, store_word, acc_next;
    logic [7:0]        tail_byte;

    assign is_str    = op_q[1];
    assign is_store  = op_q[0];
    assign word_step = !is_str || (rem_q > CW'(WORD_BYTES - 1));
    assign last_tail = (rem_q == CW'(1));
    assign rsp_take  = (st_q == ST_WAIT) && mem_rsp_valid;

    regstr_swap #(.BYTES(WORD_BYTES)) u_swap_ld (
        .en(le_q), .din(mem_rsp_rdata), .dout(load_word)
    );

    regstr_swap #(.BYTES(WORD_BYTES)) u_swap_st (
        .en(le_q), .din(rf_rd_data), .dout(store_word)
    );

    regstr_lane #(.BYTES(WORD_BYTES)) u_lane (
        .le(le_q), .idx(tail_q), .acc_in(acc_q),
        .byte_in(mem_rsp_rdata[7:0]), .reg_in(rf_rd_data),
        .acc_out(acc_next), .byte_out(tail_byte)
    );

    // Sequencer state: command capture, per-access stepping and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            op_q   <= OP_MW_LOAD;
            le_q   <= 1'b0;
            reg_q  <= '0;
            addr_q <= '0;
            rem_q  <= '0;
            tail_q <= '0;
            acc_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (cmd_valid) begin
                    op_q   <= op_e'(cmd_op);
                    le_q   <= cmd_le;
                    reg_q  <= cmd_reg;
                    addr_q <= cmd_addr;
                    rem_q  <= cmd_count;
                    tail_q <= '0;
                    acc_q  <= '0;
                    st_q   <= (cmd_op[1] && cmd_count == '0) ? ST_FINISH : ST_ISSUE;
                end
                ST_ISSUE: if (mem_req_ready) st_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    if (word_step) begin
                        reg_q  <= reg_q + 1'b1;
                        addr_q <= addr_q + AW'(WORD_BYTES);
                        if (is_str) rem_q <= rem_q - CW'(WORD_BYTES);
                        if (is_str ? (rem_q == CW'(WORD_BYTES))
                                   : (reg_q == RIDX_W'(NUM_REGS - 1)))
                            st_q <= ST_FINISH;
                        else
                            st_q <= ST_ISSUE;
                    end else begin
                        acc_q  <= acc_next;
                        tail_q <= tail_q + 1'b1;
                        addr_q <= addr_q + AW'(1);
                        rem_q  <= rem_q - CW'(1);
                        st_q   <= last_tail ? ST_FINISH : ST_ISSUE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive: the request comes from the state, the register write from the response.
    always_comb begin
        cmd_ready     = (st_q == ST_IDLE);
        done          = (st_q == ST_FINISH);
        mem_req_valid = (st_q == ST_ISSUE);
        mem_req_write = is_store;
        mem_req_byte  = !word_step;
        mem_req_addr  = addr_q;
        mem_req_wdata = word_step ? store_word : {{(WORD_W-8){1'b0}}, tail_byte};
        rf_rd_idx     = reg_q;
        rf_wr_idx     = reg_q;
        rf_wr_en      = rsp_take && !is_store && (word_step || last_tail);
        rf_wr_data    = word_step ? load_word : acc_next;
    end

    // Outstanding-access tracker used only by the checks below.
    logic out_q;
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else if (mem_req_valid && mem_req_ready) out_q <= 1'b1;
        else if (mem_rsp_valid) out_q <= 1'b0;
    end

    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !out_q);
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_byte)));
    assert_tail_bytes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_byte) |->
            (is_str && rem_q != '0 && rem_q < CW'(WORD_BYTES)));
    assert_store_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> !mem_req_write);
    assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op[1] && cmd_count == '0) |=>
            (done && !mem_req_valid && !rf_wr_en));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!rf_wr_en && !mem_req_valid));
endmodule

// File: tb/regstr_seq_test.sv
module regstr_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'b00;
    logic [4:0]  cmd_reg = '0;
    logic [31:0] cmd_addr = '0;
    logic [7:0]  cmd_count = '0;
    logic        cmd_le = 1'b0;
    logic        mem_req_valid, mem_req_write, mem_req_byte;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic [4:0]  rf_rd_idx, rf_wr_idx;
    logic [31:0] rf_rd_data, rf_wr_data;
    logic        rf_wr_en, done;

    always #(CLK_PERIOD/2) clk = ~clk;

    regstr_seq uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_reg(cmd_reg), .cmd_addr(cmd_addr), .cmd_count(cmd_count), .cmd_le(cmd_le),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_byte(mem_req_byte),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .done(done)
    );

    // Environment: register file, byte memory and reference copies.
    logic [31:0] rf [32];
    logic [7:0]  mem [256];
    logic [31:0] exp_rf [32];
    logic [7:0]  exp_mem [256];
    int          acc_cnt = 0;
    int          exp_acc = 0;
    int          overlap_err = 0;
    bit          outstanding = 0;
    logic [7:0]  lfsr = 8'h5A;
    int          n_checks = 0;
    int          n_fail = 0;

    assign rf_rd_data = rf[rf_rd_idx];

    // Register file write port model.
    always @(posedge clk) if (rf_wr_en) rf[rf_wr_idx] <= rf_wr_data;

    // Memory model: pseudo-random ready, response one cycle after acceptance.
    always @(posedge clk) begin
        logic [7:0] a;
        lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_req_ready <= lfsr[0] | lfsr[2];
        mem_rsp_valid <= 1'b0;
        if (mem_rsp_valid) outstanding = 0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (outstanding) overlap_err++;
            outstanding = 1;
            acc_cnt++;
            a = mem_req_addr[7:0];
            if (mem_req_write) begin
                if (mem_req_byte) mem[a] <= mem_req_wdata[7:0];
                else begin
                    mem[a]        <= mem_req_wdata[31:24];
                    mem[8'(a+1)]  <= mem_req_wdata[23:16];
                    mem[8'(a+2)]  <= mem_req_wdata[15:8];
                    mem[8'(a+3)]  <= mem_req_wdata[7:0];
                end
                mem_rsp_rdata <= '0;
            end else begin
                mem_rsp_rdata <= mem_req_byte ? {24'h0, mem[a]}
                               : {mem[a], mem[8'(a+1)], mem[8'(a+2)], mem[8'(a+3)]};
            end
            mem_rsp_valid <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 7 + 3 + seed * 13);
            exp_mem[i] = mem[i];
        end
        for (int r = 0; r < 32; r++) begin
            rf[r] = 32'hDE000000 | (32'(r) << 16) | 32'(seed * 257 + 1);
            exp_rf[r] = rf[r];
        end
    endtask

    // Independent reference of the requirements (R1..R7).
    task automatic ref_run(input logic [1:0] op, input logic [4:0] r0,
                           input logic [7:0] a0, input logic [7:0] n0, input logic le);
        int r = r0;
        int a = a0;
        int n = n0;
        logic [31:0] w;
        exp_acc = 0;
        if (!op[1]) begin
            for (; r < 32; r++) begin
                exp_acc++;
                word_xfer(op[0], r, a, le);
                a += 4;
            end
        end else begin
            while (n > 3) begin
                exp_acc++;
                word_xfer(op[0], r, a, le);
                r = (r + 1) % 32;
                n -= 4;
                a += 4;
            end
            if (n > 0) begin
                w = '0;
                for (int k = 0; k < n; k++) begin
                    int sh;
                    sh = le ? 8 * k : 24 - 8 * k;
                    exp_acc++;
                    if (!op[0]) w |= 32'(exp_mem[8'(a + k)]) << sh;
                    else exp_mem[8'(a + k)] = 8'(exp_rf[r] >> sh);
                end
                if (!op[0]) exp_rf[r] = w;
            end
        end
    endtask

    task automatic word_xfer(input bit st, input int r, input int a, input logic le);
        logic [31:0] w;
        if (!st) begin
            w = {exp_mem[8'(a)], exp_mem[8'(a+1)], exp_mem[8'(a+2)], exp_mem[8'(a+3)]};
            exp_rf[r] = le ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        end else begin
            w = exp_rf[r];
            if (le) w = {w[7:0], w[15:8], w[23:16], w[31:24]};
            exp_mem[8'(a)] = w[31:24]; exp_mem[8'(a+1)] = w[23:16];
            exp_mem[8'(a+2)] = w[15:8]; exp_mem[8'(a+3)] = w[7:0];
        end
    endtask

    task automatic compare(input string tag);
        int bad_r = -1;
        int bad_m = -1;
        for (int r = 31; r >= 0; r--) if (rf[r] !== exp_rf[r]) bad_r = r;
        for (int i = 255; i >= 0; i--) if (mem[i] !== exp_mem[i]) bad_m = i;
        if (bad_r >= 0) chk(0, tag, $sformatf("register %0d", bad_r), rf[bad_r], exp_rf[bad_r]);
        else chk(1, tag, "registers", 0, 0);
        if (bad_m >= 0) chk(0, tag, $sformatf("memory byte %0d", bad_m),
                            32'(mem[bad_m]), 32'(exp_mem[bad_m]));
        else chk(1, tag, "memory", 0, 0);
    endtask

    // Issue a command and wait for completion; returns number of done cycles.
    task automatic run_cmd(input logic [1:0] op, input logic [4:0] r, input logic [7:0] a,
                           input logic [7:0] n, input logic le, output int done_cnt);
        bit seen = 0;
        done_cnt = 0;
        acc_cnt = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_reg = r; cmd_addr = 32'(a);
        cmd_count = n; cmd_le = le;
        @(negedge clk);
        cmd_valid = 0;
        for (int g = 0; g < 4000; g++) begin
            if (done) begin seen = 1; done_cnt++; end
            else if (seen) break;
            @(negedge clk);
        end
    endtask

    // Stimulus table: {op, first reg, address, count, le}.
    localparam int NV = 12;
    localparam logic [23:0] VECS [NV] = '{
        {2'b00, 5'd28, 8'h10, 8'd0,  1'b0},
        {2'b01, 5'd29, 8'h40, 8'd0,  1'b0},
        {2'b00, 5'd30, 8'h20, 8'd0,  1'b1},
        {2'b01, 5'd27, 8'h70, 8'd0,  1'b1},
        {2'b10, 5'd30, 8'h05, 8'd11, 1'b0},
        {2'b10, 5'd31, 8'h08, 8'd6,  1'b1},
        {2'b11, 5'd31, 8'h80, 8'd9,  1'b0},
        {2'b11, 5'd2,  8'h90, 8'd7,  1'b1},
        {2'b10, 5'd5,  8'h30, 8'd2,  1'b0},
        {2'b11, 5'd7,  8'hA0, 8'd3,  1'b0},
        {2'b10, 5'd10, 8'h50, 8'd8,  1'b0},
        {2'b10, 5'd12, 8'h61, 8'd1,  1'b1}
    };

    function automatic string tag_of(input logic [1:0] op, input logic le);
        if (!op[1]) return le ? "R6" : "R1";
        if (op[0]) return "R7";
        return le ? "R5" : "R4";
    endfunction

    initial begin
        int dc;
        fill(0);
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(cmd_ready === 1'b1, "R10", "cmd_ready in reset", 32'(cmd_ready), 1);
        chk(done === 1'b0 && mem_req_valid === 1'b0 && rf_wr_en === 1'b0, "R10",
            "outputs quiet in reset", {29'h0, done, mem_req_valid, rf_wr_en}, 0);
        rst_n = 1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [1:0] op;
            logic [4:0] r;
            logic [7:0] a, n;
            logic le;
            {op, r, a, n, le} = VECS[v];
            fill(v + 1);
            ref_run(op, r, a, n, le);
            run_cmd(op, r, a, n, le, dc);
            compare(tag_of(op, le));
            chk(acc_cnt == exp_acc, op[1] ? "R3" : "R1", $sformatf("access count vec %0d", v),
                32'(acc_cnt), 32'(exp_acc));
            chk(dc == 1, "R10", $sformatf("done width vec %0d", v), 32'(dc), 1);
        end
        // R2: register wrap and count stepping are covered by vectors 4..7 above
        // R9: no overlapping accesses seen by the memory model
        chk(overlap_err == 0, "R9", "overlapping accesses", 32'(overlap_err), 0);

        // R8: zero-length string load and store
        fill(40);
        run_cmd(2'b10, 5'd3, 8'h10, 8'd0, 1'b0, dc);
        chk(acc_cnt == 0, "R8", "accesses for zero load", 32'(acc_cnt), 0);
        chk(dc == 1, "R8", "done for zero load", 32'(dc), 1);
        run_cmd(2'b11, 5'd3, 8'h10, 8'd0, 1'b1, dc);
        chk(acc_cnt == 0, "R8", "accesses for zero store", 32'(acc_cnt), 0);
        compare("R8");

        // R10: command presented while busy is ignored
        fill(41);
        ref_run(2'b00, 5'd30, 8'h60, 8'd0, 1'b0);
        acc_cnt = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'b00; cmd_reg = 5'd30; cmd_addr = 32'h60;
        cmd_count = 0; cmd_le = 0;
        @(negedge clk);
        chk(cmd_ready === 1'b0, "R10", "cmd_ready while busy", 32'(cmd_ready), 0);
        cmd_op = 2'b11; cmd_reg = 5'd0; cmd_addr = 32'hF0; cmd_count = 8'd4; cmd_le = 1;
        repeat (3) @(negedge clk);
        cmd_valid = 0;
        for (int g = 0; g < 4000 && !cmd_ready; g++) @(negedge clk);
        repeat (4) @(negedge clk);
        compare("R10");
        chk(acc_cnt == 2, "R10", "accesses with busy command", 32'(acc_cnt), 2);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog: actual no completion expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule